// File: doc/BRIEF.md
# Selectable-Order Burst Address Generator

This block sits in front of a synchronous pipelined memory array. It produces the array address for each cycle of a four-beat burst. Two active-low address strobes can start an access: one from the processor and one from a cache controller. When a strobe is taken, the block registers the whole address bus. The two low bits of that address become the start value of a 2-bit burst counter. After that, an active-low advance input steps the low bits through the burst, and the upper bits stay fixed.

A static strap selects the burst order. In interleaved order, the low bits are the start value XORed with the beat number. In linear order, the low bits count upward modulo four from the start value.

Only a selected device honours a strobe. The device is selected when the decoded chip-select qualifier is high and the first chip enable is low. The processor strobe is ignored entirely while that enable is high. A strobe that reaches a deselected device ends the current burst. Each accepted strobe produces a one-cycle load indication for the access controller, together with a flag that tells which strobe won.

Top module: `burst_addr_gen`

## Requirements
- R1: When a strobe is accepted at a clock rise, `arr_addr` equals the sampled `addr_in` from the next cycle on. `load_pulse` is high for exactly that one cycle, and `burst_live` goes high.
- R2: If both strobes are low at the same rise with `ce1_n` low, the processor strobe wins and `load_by_proc` reads 1 alongside `load_pulse`. A controller-only load gives 0. The flag holds its value between loads.
- R3: While `ce1_n` is high, a low `ps_n` is ignored. With `cs_n` high there is no load, and an active burst carries on as if no strobe were present.
- R4: A strobe that is taken while the device is not selected clears `burst_live` and leaves `arr_addr` unchanged. Selected means `sel_ok` is 1 and `ce1_n` is 0. A low `cs_n` with `ce1_n` high also counts as such a strobe. While `burst_live` is 0, advance has no effect.
- R5: With `order_strap` = 1 (interleaved), the low two address bits on beat k are start XOR k. For example, start 01 gives 01,00,11,10 and start 10 gives 10,11,00,01.
- R6: With `order_strap` = 0 (linear), the low two address bits on beat k are (start + k) mod 4. For example, start 01 gives 01,10,11,00.
- R7: In a live burst with no strobe, `adv_n` low at a rise moves to the next beat. `adv_n` high keeps `arr_addr` unchanged, which suspends the burst.
- R8: `adv_n` is ignored in a cycle in which a strobe loads a new address. The first beat is always the start address.
- R9: After the fourth beat, the counter wraps to beat 0 and keeps cycling while advance stays low. The bits of `arr_addr` above bit 1 never change except on a load.
- R10: Synchronous reset sets `arr_addr`, `load_pulse`, `load_by_proc` and `burst_live` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | Address bus sampled on a strobe |
| ps_n | input | 1 | Processor address strobe, active low, gated by `ce1_n` |
| cs_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_ok | input | 1 | Decoded qualifier from the other chip selects, active high |
| ce1_n | input | 1 | First chip enable, active low |
| order_strap | input | 1 | Burst order strap: 1 interleaved, 0 linear |
| arr_addr | output | ADDR_W | Current array address (registered) |
| load_pulse | output | 1 | One-cycle indication that a new access started |
| load_by_proc | output | 1 | 1 if the last load came from the processor strobe |
| burst_live | output | 1 | A selected access is in progress |

## Verification
A strobe load and an advance can fall on the same clock rise. In that case the advance must lose: the first beat must show the new start address exactly. The bench provokes this by holding `adv_n` low during load cycles in both orders. It also starts loads in the middle of running bursts. A cycle-by-cycle model judges every cycle: it applies the load and discards the advance. The same collision is repeated under random strobe, select and advance patterns.

// File: rtl/bag_pkg.sv
`timescale 1ns/1ps
package bag_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef struct packed {
    logic seen;     // an honoured strobe is present
    logic load;     // strobe accepted by a selected device
    logic desel;    // strobe with the device not selected
    logic by_proc;  // the processor strobe is the one honoured
  } strobe_t;

endpackage

// File: rtl/bag_strobe_arb.sv
`timescale 1ns/1ps
module bag_strobe_arb
  import bag_pkg::*;
(
  input  logic    ps_n,
  input  logic    cs_n,
  input  logic    ce1_n,
  input  logic    sel_ok,
  output strobe_t res
);

  logic proc_hit;
  logic ctrl_hit;
  logic chip_on;

  always_comb begin
    proc_hit    = !ps_n && !ce1_n;
    ctrl_hit    = !cs_n && !proc_hit;
    chip_on     = sel_ok && !ce1_n;
    res.seen    = proc_hit || ctrl_hit;
    res.load    = res.seen && chip_on;
    res.desel   = res.seen && !chip_on;
    res.by_proc = proc_hit;
  end

endmodule

// File: rtl/bag_burst_ctr.sv
`timescale 1ns/1ps
module bag_burst_ctr
  import bag_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  order_e            order,
  input  logic [BEAT_W-1:0] start_in,
  output logic [BEAT_W-1:0] low_q
);

  localparam int BURST_LEN = 1 << BEAT_W;

  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] beat_nx;
  logic [BEAT_W-1:0] low_nx;

  always_comb begin
    beat_nx = beat_q + 1'b1;
    if (order == ORD_INTERLEAVE) low_nx = start_q ^ beat_nx;
    else                         low_nx = start_q + beat_nx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
      low_q   <= '0;
    end else if (load) begin
      start_q <= start_in;
      beat_q  <= '0;
      low_q   <= start_in;
    end else if (step) begin
      beat_q  <= beat_nx;
      low_q   <= low_nx;
    end
  end

  // R7
  low_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (low_q != $past(low_q)));

  // R8
  low_start_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (low_q == $past(start_in)));

  initial begin
    if (BURST_LEN < 2) $error("burst length must be at least two");
  end

endmodule

// File: rtl/bag_upper_reg.sv
`timescale 1ns/1ps
module bag_upper_reg #(
  parameter int HI_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [HI_W-1:0] hi_in,
  output logic [HI_W-1:0] hi_q
);

  always_ff @(posedge clk) begin
    if (rst)       hi_q <= '0;
    else if (load) hi_q <= hi_in;
  end

  // R9
  hi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(hi_q));

endmodule

// File: rtl/burst_addr_gen.sv
`timescale 1ns/1ps
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ps_n,
  input  logic              cs_n,
  input  logic              adv_n,
  input  logic              sel_ok,
  input  logic              ce1_n,
  input  logic              order_strap,
  output logic [ADDR_W-1:0] arr_addr,
  output logic              load_pulse,
  output logic              load_by_proc,
  output logic              burst_live
);

  localparam int HI_W = ADDR_W - BEAT_W;

  strobe_t           sres;
  order_e            order;
  logic              step;
  logic [HI_W-1:0]   hi_q;
  logic [BEAT_W-1:0] low_q;

  bag_strobe_arb u_arb (
    .ps_n   (ps_n),
    .cs_n   (cs_n),
    .ce1_n  (ce1_n),
    .sel_ok (sel_ok),
    .res    (sres)
  );

  always_comb begin
    order = order_strap ? ORD_INTERLEAVE : ORD_LINEAR;
    step  = burst_live && !adv_n && !sres.seen;
  end

  bag_upper_reg #(.HI_W(HI_W)) u_hi (
    .clk   (clk),
    .rst   (rst),
    .load  (sres.load),
    .hi_in (addr_in[ADDR_W-1:BEAT_W]),
    .hi_q  (hi_q)
  );

  bag_burst_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (sres.load),
    .step     (step),
    .order    (order),
    .start_in (addr_in[BEAT_W-1:0]),
    .low_q    (low_q)
  );

  assign arr_addr = {hi_q, low_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      load_pulse   <= 1'b0;
      load_by_proc <= 1'b0;
      burst_live   <= 1'b0;
    end else begin
      load_pulse <= sres.load;
      if (sres.load) begin
        load_by_proc <= sres.by_proc;
        burst_live   <= 1'b1;
      end else if (sres.desel) begin
        burst_live   <= 1'b0;
      end
    end
  end

  // R1
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !ce1_n && sel_ok) |=> (arr_addr == $past(addr_in) && load_pulse && burst_live));

  // R2
  proc_prio_chk: assert property (@(posedge clk) disable iff (rst)
    (!ps_n && !cs_n && !ce1_n && sel_ok) |=> load_by_proc);

  // R3
  ce1_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ce1_n && cs_n) |=> !load_pulse);

  // R4
  desel_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && ce1_n) |=> (!burst_live && $stable(arr_addr)));

  // R7
  suspend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ps_n && cs_n && adv_n) |=> $stable(arr_addr));

  // R1
  pulse_live_chk: assert property (@(posedge clk) disable iff (rst)
    load_pulse |-> burst_live);

endmodule

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr_in;
  logic          ps_n, cs_n, adv_n, sel_ok, ce1_n, order_strap;
  logic [AW-1:0] arr_addr;
  logic          load_pulse, load_by_proc, burst_live;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int m_hi, m_start, m_beat, m_low;
  bit m_live, m_load, m_proc;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u0 (
    .clk(clk), .rst(rst), .addr_in(addr_in), .ps_n(ps_n), .cs_n(cs_n),
    .adv_n(adv_n), .sel_ok(sel_ok), .ce1_n(ce1_n), .order_strap(order_strap),
    .arr_addr(arr_addr), .load_pulse(load_pulse), .load_by_proc(load_by_proc),
    .burst_live(burst_live)
  );

  function automatic int beat_low(int s, int k, bit inter);
    if (inter) return s ^ k;
    return (s + k) % 4;
  endfunction

  task automatic model_update();
    bit p, c, on;
    m_load = 0;
    if (rst) begin
      m_hi = 0; m_start = 0; m_beat = 0; m_low = 0;
      m_live = 0; m_proc = 0;
    end else begin
      p  = !ps_n && !ce1_n;
      c  = !cs_n && !p;
      on = sel_ok && !ce1_n;
      if ((p || c) && on) begin
        m_hi = int'(addr_in) / 4;
        m_start = int'(addr_in) % 4;
        m_beat = 0;
        m_low = m_start;
        m_live = 1; m_load = 1; m_proc = p;
      end else if (p || c) begin
        m_live = 0;
      end else if (m_live && !adv_n) begin
        m_beat = (m_beat + 1) % 4;
        m_low = beat_low(m_start, m_beat, order_strap);
      end
    end
  endtask

  task automatic tick(input string tag);
    logic [AW-1:0] exp_a;
    @(posedge clk);
    model_update();
    @(negedge clk);
    exp_a = AW'(m_hi * 4 + m_low);
    checks++;
    if (arr_addr !== exp_a || load_pulse !== m_load ||
        load_by_proc !== m_proc || burst_live !== m_live) begin
      fails++;
      $display("FAIL %s: addr=%h load=%b proc=%b live=%b expected addr=%h load=%b proc=%b live=%b",
               tag, arr_addr, load_pulse, load_by_proc, burst_live,
               exp_a, m_load, m_proc, m_live);
    end
  endtask

  task automatic drive(input bit p, input bit c, input bit a, input bit e1,
                       input bit s, input int ad, input string tag);
    ps_n = p; cs_n = c; adv_n = a; ce1_n = e1; sel_ok = s;
    addr_in = AW'(ad);
    tick(tag);
  endtask

  initial begin
    rst = 1'b1; addr_in = '0; ps_n = 1; cs_n = 1; adv_n = 1;
    sel_ok = 1; ce1_n = 0; order_strap = 1;
    tick("R10"); tick("R10");
    rst = 1'b0;
    tick("R10");

    // interleaved, controller load start 01, advance held low during load
    drive(1, 0, 0, 0, 1, 'h12345, "R8");
    for (int i = 0; i < 6; i++) drive(1, 1, 0, 0, 1, 'h0, "R5");
    drive(1, 1, 1, 0, 1, 'h0, "R7");
    drive(1, 1, 1, 0, 1, 'h0, "R7");
    drive(1, 1, 0, 0, 1, 'h0, "R9");
    // start 10 interleaved
    drive(0, 1, 1, 0, 1, 'h0AAA6, "R1");
    for (int i = 0; i < 4; i++) drive(1, 1, 0, 0, 1, 'h0, "R5");

    // linear order
    order_strap = 0;
    drive(1, 0, 0, 0, 1, 'h1F001, "R8");
    for (int i = 0; i < 6; i++) drive(1, 1, 0, 0, 1, 'h0, "R6");
    drive(1, 1, 1, 0, 1, 'h0, "R7");

    // both strobes selected: processor wins, then controller-only
    drive(0, 0, 1, 0, 1, 'h00333, "R2");
    drive(1, 1, 1, 0, 1, 'h0, "R2");
    drive(1, 0, 1, 0, 1, 'h00444, "R2");
    drive(1, 1, 1, 0, 1, 'h0, "R2");

    // processor strobe with ce1 high is ignored, burst carries on
    drive(0, 1, 0, 1, 1, 'h1FFFF, "R3");
    drive(0, 1, 0, 1, 0, 'h1FFFF, "R3");
    drive(0, 1, 1, 1, 1, 'h1FFFF, "R3");

    // deselects: controller with ce1 high, processor with sel_ok low
    drive(1, 0, 0, 1, 1, 'h05555, "R4");
    drive(1, 1, 0, 0, 1, 'h0, "R4");
    drive(1, 0, 1, 0, 1, 'h06667, "R1");
    drive(0, 1, 0, 0, 0, 'h07777, "R4");
    drive(1, 1, 0, 0, 1, 'h0, "R4");

    // random mix, strap switched only at loads
    for (int i = 0; i < 600; i++) begin
      if (i % 150 == 0) begin
        order_strap = ~order_strap;
        drive(1, 0, 0, 0, 1, int'($urandom % (1 << AW)), "R6");
      end else begin
        drive(($urandom % 4) != 0, ($urandom % 5) != 0, ($urandom % 3) == 0,
              ($urandom % 6) == 0, ($urandom % 7) != 0,
              int'($urandom % (1 << AW)), "R9");
      end
    end

    rst = 1'b1;
    tick("R10");
    rst = 1'b0;
    tick("R10");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule